// File: doc/BRIEF.md
# Register-Write Command Stream Executor

This block is a small fetch-and-execute engine for a display or peripheral subsystem. Software places a list of register-write instructions in memory, then programs a start pointer and an end pointer into the engine. The engine reads the list as 64-bit words through a memory read port that uses a valid/ready handshake. It decodes each instruction and drives a local register write port with an offset, a data word and byte enables. It issues no register reads.

Two instruction forms exist. A direct write occupies one 64-bit word and carries its own byte enables. An indexed write starts with a 64-bit word that holds a dword count N and the target offset. It is followed by N data dwords, all sent to that one offset. A zero dword pads the sequence when needed, so that the next instruction starts on a 64-bit boundary. A word whose opcode field is zero does nothing. Software can therefore fill the gap up to a line-rounded end pointer with zeros. The engine shows a busy bit while it runs. An unknown opcode stops the run and sets a sticky error bit.

Top module: `rwq_engine`

## Requirements
- R1: After reset, the control register, the start pointer and the end pointer all read 0. No memory request and no register write is issued.
- R2: The configuration map has three registers. Address 0 is control: bit 0 enable (read/write), bit 1 busy (read-only), bit 2 error (read-only, sticky). Address 1 is the start pointer and address 2 is the end pointer, both byte addresses whose low 3 bits are stored as 0. Read data appears one cycle after the address is presented.
- R3: A write to the end pointer starts a run when enable is 1, the engine is idle and the new end pointer differs from the start pointer. Busy then reads 1 until the fetch position reaches the end pointer. Each 64-bit word from the start pointer up to, but not including, the end pointer is fetched once, in ascending order. If enable is 0, an end pointer write only stores the pointer.
- R4: Direct write. In a 64-bit word, bits 31:0 are the data and bits 63:56 hold opcode 0x01. Bits 55:52 are the byte enables and bits 51:32 are the 20-bit register offset. The word produces exactly one register write with those values.
- R5: Indexed write. In the first word, bits 31:0 hold the count N, bits 63:56 hold opcode 0x09 and bits 51:32 hold the offset. The next N dwords are written, in order, to that offset with byte enables 0xF. Within each 64-bit word the low dword comes first. N = 0 writes nothing, and the next word is a new instruction.
- R6: When N is odd, the upper dword of the last data word is padding. It is not written, and the next instruction starts at the following 64-bit word.
- R7: A word with opcode 0x00 is a no-op. A run over zero-filled words issues no register writes.
- R8: A word with any other opcode writes nothing. It sets the error bit, ends the run (busy clears) and stops all further fetches.
- R9: While busy, writes to the control register, the start pointer and the end pointer are ignored.
- R10: While idle, writing control with bit 0 = 0 clears enable, the error bit and both pointers.
- R11: A memory request stays asserted with a stable address until it is accepted. Any number of stall cycles on the request or the response leaves the sequence of register writes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, registered |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_ready | input | 1 | Fetch request accepted |
| mem_req_addr | output | ADDR_W | Byte address of the 64-bit word to fetch |
| mem_rsp_valid | input | 1 | Fetch response valid |
| mem_rsp_data | input | 64 | Fetched 64-bit word |
| reg_wr_valid | output | 1 | Register write strobe |
| reg_wr_addr | output | 20 | Register offset |
| reg_wr_data | output | 32 | Register write data |
| reg_wr_be | output | 4 | Register byte enables |

## Verification
The bench builds the engine with ADDR_W = 9. The pointer space is then 512 bytes, or 64 words, and the bench memory backs every address the engine can request. Start and end pointers can therefore be placed anywhere, including the top of the space. Each scenario runs with request and response stalls either off or driven by a pseudo-random pattern. This shows that the order and content of the register writes do not depend on memory timing. Indexed writes with odd, even and zero counts, zero-filled tails, an unknown opcode, and pointer writes during a run reach the cases where the decode state matters.

// File: rtl/rwq_pkg.sv
package rwq_pkg;
  localparam int OFS_W = 20;
  localparam logic [7:0] OP_NOP     = 8'h00;
  localparam logic [7:0] OP_DIRECT  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;

  localparam logic [1:0] CSR_CTRL = 2'd0;
  localparam logic [1:0] CSR_HEAD = 2'd1;
  localparam logic [1:0] CSR_TAIL = 2'd2;

  typedef struct packed {
    logic [7:0]       op;
    logic [3:0]       be;
    logic [OFS_W-1:0] ofs;
  } cmd_word_t;

  typedef enum logic [1:0] {
    F_IDLE,
    F_REQ,
    F_WAIT,
    F_NEXT
  } fetch_state_t;
endpackage

// File: rtl/rwq_csr.sv
module rwq_csr
  import rwq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              fetch_busy,
  input  logic              err_evt,
  output logic              start,
  output logic              busy_any,
  output logic              err_flag,
  output logic [ADDR_W-4:0] head_ptr,
  output logic [ADDR_W-4:0] tail_ptr
);
  localparam int PTR_W = ADDR_W - 3;

  logic             enable;
  logic [PTR_W-1:0] wr_ptr;
  logic             unused_wbits;

  assign wr_ptr       = cfg_wdata[ADDR_W-1:3];
  assign unused_wbits = ^{cfg_wdata[31:ADDR_W], cfg_wdata[2:1]};
  assign busy_any     = fetch_busy | start;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable    <= 1'b0;
      err_flag  <= 1'b0;
      head_ptr  <= '0;
      tail_ptr  <= '0;
      start     <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      start <= 1'b0;
      if (err_evt) err_flag <= 1'b1;
      if (cfg_we && !busy_any) begin
        case (cfg_addr)
          CSR_CTRL: begin
            if (!cfg_wdata[0]) begin
              enable   <= 1'b0;
              err_flag <= 1'b0;
              head_ptr <= '0;
              tail_ptr <= '0;
            end else begin
              enable <= 1'b1;
            end
          end
          CSR_HEAD: head_ptr <= wr_ptr;
          CSR_TAIL: begin
            tail_ptr <= wr_ptr;
            if (enable && (wr_ptr != head_ptr)) start <= 1'b1;
          end
          default: ;
        endcase
      end
      case (cfg_addr)
        CSR_CTRL: cfg_rdata <= {29'd0, err_flag, busy_any, enable};
        CSR_HEAD: cfg_rdata <= 32'({head_ptr, 3'b000});
        CSR_TAIL: cfg_rdata <= 32'({tail_ptr, 3'b000});
        default:  cfg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rwq_fetch.sv
module rwq_fetch
  import rwq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-4:0] head_ptr,
  input  logic [ADDR_W-4:0] tail_ptr,
  input  logic              dec_hold,
  input  logic              dec_err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              q_valid,
  output logic              busy
);
  localparam int PTR_W = ADDR_W - 3;

  fetch_state_t     state;
  logic [PTR_W-1:0] ptr;

  assign mem_req_valid = (state == F_REQ);
  assign mem_req_addr  = {ptr, 3'b000};
  assign q_valid       = (state == F_WAIT) && mem_rsp_valid;
  assign busy          = (state != F_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= F_IDLE;
      ptr   <= '0;
    end else begin
      case (state)
        F_IDLE: if (start) begin
          ptr   <= head_ptr;
          state <= F_REQ;
        end
        F_REQ: if (mem_req_ready) state <= F_WAIT;
        F_WAIT: if (mem_rsp_valid) begin
          ptr   <= ptr + 1'b1;
          state <= F_NEXT;
        end
        F_NEXT: begin
          if (dec_err)               state <= F_IDLE;
          else if (dec_hold)         state <= F_NEXT;
          else if (ptr == tail_ptr)  state <= F_IDLE;
          else                       state <= F_REQ;
        end
        default: state <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rwq_decode.sv
module rwq_decode
  import rwq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             q_valid,
  input  logic [63:0]      q_data,
  output logic             hold,
  output logic             err_evt,
  output logic             wr_valid,
  output logic [OFS_W-1:0] wr_addr,
  output logic [31:0]      wr_data,
  output logic [3:0]       wr_be
);
  cmd_word_t        hi_w;
  logic [31:0]      lo_w;
  logic [31:0]      remain;
  logic [OFS_W-1:0] tgt;
  logic [31:0]      hi_buf;

  assign hi_w = q_data[63:32];
  assign lo_w = q_data[31:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_be    <= '0;
      remain   <= '0;
      tgt      <= '0;
      hi_buf   <= '0;
      hold     <= 1'b0;
      err_evt  <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      err_evt  <= 1'b0;
      if (start) begin
        remain <= '0;
        hold   <= 1'b0;
      end else if (hold) begin
        wr_valid <= 1'b1;
        wr_addr  <= tgt;
        wr_data  <= hi_buf;
        wr_be    <= 4'hF;
        remain   <= remain - 1'b1;
        hold     <= 1'b0;
      end else if (q_valid) begin
        if (remain != 0) begin
          wr_valid <= 1'b1;
          wr_addr  <= tgt;
          wr_data  <= lo_w;
          wr_be    <= 4'hF;
          remain   <= remain - 1'b1;
          if (remain > 32'd1) begin
            hold   <= 1'b1;
            hi_buf <= q_data[63:32];
          end
        end else begin
          case (hi_w.op)
            OP_NOP: ;
            OP_DIRECT: begin
              wr_valid <= 1'b1;
              wr_addr  <= hi_w.ofs;
              wr_data  <= lo_w;
              wr_be    <= hi_w.be;
            end
            OP_INDEXED: begin
              remain <= lo_w;
              tgt    <= hi_w.ofs;
            end
            default: err_evt <= 1'b1;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/rwq_engine.sv
module rwq_engine
  import rwq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              reg_wr_valid,
  output logic [19:0]       reg_wr_addr,
  output logic [31:0]       reg_wr_data,
  output logic [3:0]        reg_wr_be
);
  logic              start;
  logic              busy_any;
  logic              err_flag;
  logic              fetch_busy;
  logic              q_valid;
  logic              dec_hold;
  logic              dec_err;
  logic [ADDR_W-4:0] head_ptr;
  logic [ADDR_W-4:0] tail_ptr;

  rwq_csr #(.ADDR_W(ADDR_W)) u_csr (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fetch_busy(fetch_busy), .err_evt(dec_err),
    .start(start), .busy_any(busy_any), .err_flag(err_flag),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr)
  );

  rwq_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst(rst), .start(start),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr),
    .dec_hold(dec_hold), .dec_err(dec_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .q_valid(q_valid), .busy(fetch_busy)
  );

  rwq_decode u_decode (
    .clk(clk), .rst(rst), .start(start),
    .q_valid(q_valid), .q_data(mem_rsp_data),
    .hold(dec_hold), .err_evt(dec_err),
    .wr_valid(reg_wr_valid), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .wr_be(reg_wr_be)
  );
endmodule

// File: rtl/rwq_engine_chk.sv
module rwq_engine_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              err_flag,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              reg_wr_valid,
  input logic              cfg_we,
  input logic [1:0]        cfg_addr,
  input logic [ADDR_W-4:0] head_ptr,
  input logic [ADDR_W-4:0] tail_ptr
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_req_in_run_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy);

  assert_write_in_run_R4: assert property (@(posedge clk) disable iff (rst)
    reg_wr_valid |-> busy);

  assert_head_locked_R9: assert property (@(posedge clk) disable iff (rst)
    busy && cfg_we && (cfg_addr == 2'd1) |=> $stable(head_ptr));

  assert_tail_locked_R9: assert property (@(posedge clk) disable iff (rst)
    busy && cfg_we && (cfg_addr == 2'd2) |=> $stable(tail_ptr));

  assert_error_ends_run_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> !busy);
endmodule

bind rwq_engine rwq_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .busy(fetch_busy), .err_flag(err_flag),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .reg_wr_valid(reg_wr_valid),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .head_ptr(head_ptr), .tail_ptr(tail_ptr)
);

// File: tb/rwq_engine_bench.sv
`timescale 1ns/1ps
module rwq_engine_bench;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = 2'd0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          mem_req_valid, mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [63:0]   mem_rsp_data = '0;
  logic          reg_wr_valid;
  logic [19:0]   reg_wr_addr;
  logic [31:0]   reg_wr_data;
  logic [3:0]    reg_wr_be;

  always #2.5 clk = ~clk;

  rwq_engine #(.ADDR_W(AW)) u_rwq_engine (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .reg_wr_valid(reg_wr_valid), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_wr_be(reg_wr_be)
  );

  // memory model: one outstanding request, optional pseudo-random stalls
  logic [63:0] mem [64];
  logic        stall_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        pend = 1'b0;
  logic [5:0]  paddr = '0;
  logic [1:0]  lat = '0;

  assign mem_req_ready = !stall_on || lfsr[0];

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (lat == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[paddr];
        pend          <= 1'b0;
      end else begin
        lat <= lat - 1'b1;
      end
    end else if (mem_req_valid && mem_req_ready) begin
      pend  <= 1'b1;
      paddr <= mem_req_addr[8:3];
      lat   <= stall_on ? lfsr[2:1] : 2'd0;
    end
  end

  // write and fetch monitors
  logic [19:0] w_addr [256];
  logic [31:0] w_data [256];
  logic [3:0]  w_be   [256];
  int wcnt = 0;
  int fcnt = 0;
  always @(posedge clk) begin
    if (reg_wr_valid && wcnt < 256) begin
      w_addr[wcnt] <= reg_wr_addr;
      w_data[wcnt] <= reg_wr_data;
      w_be[wcnt]   <= reg_wr_be;
      wcnt <= wcnt + 1;
    end
    if (mem_req_valid && mem_req_ready) fcnt <= fcnt + 1;
  end

  int checks = 0;
  int fails = 0;

  task automatic check_eq(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] v;
    int n = 0;
    do begin
      cfg_rd(2'd0, v);
      n++;
    end while (v[1] && n < 3000);
    ok = !v[1];
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
  endtask

  task automatic run(input int head, input int tail, input string req);
    bit ok;
    cfg_wr(2'd1, 32'(head));
    cfg_wr(2'd2, 32'(tail));
    wait_idle(ok);
    check_eq(req, "run completes", 64'(ok), 64'd1);
  endtask

  task automatic chk_wr(input int idx, input logic [19:0] a, input logic [31:0] d,
                        input logic [3:0] be, input string req);
    check_eq(req, "write offset", 64'(w_addr[idx]), 64'(a));
    check_eq(req, "write data",   64'(w_data[idx]), 64'(d));
    check_eq(req, "write enables", 64'(w_be[idx]),  64'(be));
  endtask

  // {stall, data dword, command dword, expected enables, expected offset}
  localparam logic [88:0] VEC [6] = '{
    {1'b0, 32'hDEADBEEF, 32'h01F00004, 4'hF, 20'h00004},
    {1'b1, 32'h00000001, 32'h011FFFFF, 4'h1, 20'hFFFFF},
    {1'b0, 32'hA5A55A5A, 32'h01812340, 4'h8, 20'h12340},
    {1'b1, 32'h00000000, 32'h01600000, 4'h6, 20'h00000},
    {1'b1, 32'hFFFFFFFF, 32'h01A00ABC, 4'hA, 20'h00ABC},
    {1'b0, 32'h12345678, 32'h01300100, 4'h3, 20'h00100}
  };

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int wb, fb;
    clear_mem();
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_eq("R1", "request idle", 64'(mem_req_valid), 64'd0);
    cfg_rd(2'd0, rv); check_eq("R1", "ctrl", 64'(rv), 64'd0);
    cfg_rd(2'd1, rv); check_eq("R1", "head", 64'(rv), 64'd0);
    cfg_rd(2'd2, rv); check_eq("R1", "tail", 64'(rv), 64'd0);
    check_eq("R1", "no writes", 64'(wcnt), 64'd0);

    // R2 pointer alignment; R3 end pointer write without enable
    cfg_wr(2'd1, 32'h1F7);
    cfg_rd(2'd1, rv); check_eq("R2", "head low bits dropped", 64'(rv), 64'h1F0);
    fb = fcnt;
    cfg_wr(2'd2, 32'h040);
    repeat (10) @(negedge clk);
    cfg_rd(2'd0, rv); check_eq("R3", "no start when disabled", 64'(rv), 64'd0);
    check_eq("R3", "no fetch when disabled", 64'(fcnt - fb), 64'd0);
    cfg_rd(2'd2, rv); check_eq("R3", "tail stored", 64'(rv), 64'h040);

    // R10 disable clears pointers
    cfg_wr(2'd0, 32'd0);
    cfg_rd(2'd1, rv); check_eq("R10", "head cleared", 64'(rv), 64'd0);
    cfg_rd(2'd2, rv); check_eq("R10", "tail cleared", 64'(rv), 64'd0);

    cfg_wr(2'd0, 32'd1);
    cfg_rd(2'd0, rv); check_eq("R2", "enable bit", 64'(rv), 64'd1);

    // table: one direct write followed by zero fill to a 64-byte end
    for (int i = 0; i < 6; i++) begin
      logic [88:0] v;
      int head;
      v = VEC[i];
      head = (i * 64) % 448;
      clear_mem();
      mem[head / 8] = {v[55:24], v[87:56]};
      stall_on = v[88];
      wb = wcnt; fb = fcnt;
      run(head, head + 64, "R3");
      check_eq("R7", "one write only", 64'(wcnt - wb), 64'd1);
      check_eq("R3", "word fetch count", 64'(fcnt - fb), 64'd8);
      chk_wr(wb, v[19:0], v[87:56], v[23:20], "R4");
    end

    // R5/R6: odd count with padding, then a direct write, stalls on (R11)
    clear_mem();
    mem[32] = {32'h09000ABC, 32'd3};
    mem[33] = {32'h22220002, 32'h11110001};
    mem[34] = {32'h00000000, 32'h33330003};
    mem[35] = {32'h01512345, 32'hCAFEF00D};
    stall_on = 1'b1;
    wb = wcnt; fb = fcnt;
    run(32'h100, 32'h140, "R6");
    check_eq("R6", "write count", 64'(wcnt - wb), 64'd4);
    chk_wr(wb,     20'h00ABC, 32'h11110001, 4'hF, "R5");
    chk_wr(wb + 1, 20'h00ABC, 32'h22220002, 4'hF, "R5");
    chk_wr(wb + 2, 20'h00ABC, 32'h33330003, 4'hF, "R11");
    chk_wr(wb + 3, 20'h12345, 32'hCAFEF00D, 4'h5, "R6");

    // R5: even count, zero count, then direct, no stalls, top of space
    clear_mem();
    mem[56] = {32'h09000010, 32'd2};
    mem[57] = {32'hE0000002, 32'hE0000001};
    mem[58] = {32'h09000020, 32'd0};
    mem[59] = {32'h01F00030, 32'h00000055};
    stall_on = 1'b0;
    wb = wcnt;
    run(32'h1C0, 32'h1E0, "R5");
    check_eq("R5", "write count", 64'(wcnt - wb), 64'd3);
    chk_wr(wb,     20'h00010, 32'hE0000001, 4'hF, "R5");
    chk_wr(wb + 1, 20'h00010, 32'hE0000002, 4'hF, "R5");
    chk_wr(wb + 2, 20'h00030, 32'h00000055, 4'hF, "R5");

    // R8 unknown opcode
    clear_mem();
    mem[16] = {32'h01F00200, 32'h11};
    mem[17] = {32'h07000000, 32'h22};
    mem[18] = {32'h01F00300, 32'h33};
    stall_on = 1'b1;
    wb = wcnt; fb = fcnt;
    run(32'h080, 32'h098, "R8");
    check_eq("R8", "writes before error", 64'(wcnt - wb), 64'd1);
    check_eq("R8", "fetch stops", 64'(fcnt - fb), 64'd2);
    chk_wr(wb, 20'h00200, 32'h11, 4'hF, "R8");
    cfg_rd(2'd0, rv); check_eq("R8", "ctrl error set", 64'(rv), 64'h5);

    // R9 writes during a run are ignored
    clear_mem();
    mem[0] = {32'h09000077, 32'd12};
    for (int k = 1; k <= 6; k++) mem[k] = {32'(k * 2 + 1), 32'(k * 2)};
    wb = wcnt;
    cfg_wr(2'd1, 32'h000);
    cfg_wr(2'd2, 32'h040);
    cfg_rd(2'd0, rv); check_eq("R9", "busy during run", 64'(rv[1]), 64'd1);
    cfg_wr(2'd1, 32'h100);
    cfg_wr(2'd2, 32'h1C0);
    cfg_wr(2'd0, 32'h000);
    begin
      bit ok;
      wait_idle(ok);
      check_eq("R9", "run completes", 64'(ok), 64'd1);
    end
    cfg_rd(2'd1, rv); check_eq("R9", "head kept", 64'(rv), 64'h000);
    cfg_rd(2'd2, rv); check_eq("R9", "tail kept", 64'(rv), 64'h040);
    cfg_rd(2'd0, rv); check_eq("R9", "ctrl kept", 64'(rv), 64'h5);
    check_eq("R5", "twelve writes", 64'(wcnt - wb), 64'd12);
    for (int k = 0; k < 12; k++) chk_wr(wb + k, 20'h00077, 32'(k + 2), 4'hF, "R5");

    // R10 disable while idle clears error
    cfg_wr(2'd0, 32'd0);
    cfg_rd(2'd0, rv); check_eq("R10", "ctrl cleared", 64'(rv), 64'd0);
    cfg_rd(2'd2, rv); check_eq("R10", "tail cleared", 64'(rv), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule